// File: doc/BRIEF.md
# 16-bit Register Byte-Access Bridge

This block lets an 8-bit processor bus reach a small bank of 16-bit registers without tearing their values. Each 16-bit register takes two adjacent byte addresses. The even address is the low half and the odd address is the high half. A single holding byte, shared by the whole bank, sits between the bus and every upper half. Reading a low half copies that register's upper byte into the holding byte in the same cycle, so a later read of the high address returns a snapshot taken together with the low byte. Writing a high address only fills the holding byte. The following write to a low address then commits all sixteen bits at once.

Register index 0 is a built-in free-running 16-bit up-counter. Indexes 1 to `NUM_EXT` belong to external peripheral registers. These are read through a packed value input. They are written through a per-register one-cycle load strobe together with a shared 16-bit write-data output. Software reads a pair low byte first and writes a pair high byte first.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, the counter is 0x0000 and the holding byte is 0x00. A read of any high address then returns 0x00, and no load strobe is active.
- R2: A read of an even (low) mapped address returns bits 7:0 of that register's current value. In the same cycle, bits 15:8 are copied into the holding byte. A later high-address read returns that copy even if the register has changed since.
- R3: A read or write of an odd (high) mapped address reaches only the holding byte. A write sets the holding byte to the bus data. No register value changes and no load strobe fires.
- R4: A write to an even mapped address loads the full 16 bits in that single clock edge, with the holding byte as bits 15:8 and the bus data as bits 7:0. For an external register, exactly that register's strobe pulses for one cycle. Register k occupies addresses 2k (low) and 2k+1 (high).
- R5: When a low-byte write to the counter coincides with an enabled count, the written value is loaded and that cycle's increment is dropped.
- R6: The holding byte is shared by all registers. An access to another register's low byte between the high-byte write and the low-byte write of a sequence replaces the upper byte that gets committed.
- R7: Addresses at or above 2*(NUM_EXT+1) are unmapped. Reads of them return 0x00. Writes to them change neither the holding byte, the counter, nor any strobe.
- R8: While the count enable is high, the counter adds one per clock edge and wraps from 0xFFFF to 0x0000.
- R9: The read data bus is 0x00 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bit 0 selects high (1) or low (0) half |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rdata | output | 8 | Read data byte |
| cnt_en | input | 1 | Counter increment enable |
| cnt_value | output | 16 | Current counter value |
| ext_load | output | NUM_EXT | One-cycle load strobe per external register |
| ext_wdata | output | 16 | Combined 16-bit value to load into an external register |
| ext_value | input | 16*NUM_EXT | Packed current values of the external registers, register 1 in the lowest slice |

## Verification
The bench reads the counter low byte while it is counting and then reads the high byte. A bridge that passed the live upper byte through would return the already-incremented value instead of the snapshot. It writes the counter while the count is enabled, which catches a design that adds one on top of the written value. It also inserts a foreign low-byte read between the halves of a write, where a per-register holding byte would wrongly keep the first upper byte. Finally, it probes unmapped and high addresses to catch strobes or register updates that should never happen, and checks the 0xFFFF wrap.

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int ADDR_W  = 4,
  parameter int NUM_EXT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  output logic [7:0]           bus_rdata,
  input  logic                 cnt_en,
  output logic [15:0]          cnt_value,
  output logic [NUM_EXT-1:0]   ext_load,
  output logic [15:0]          ext_wdata,
  input  logic [16*NUM_EXT-1:0] ext_value
);
  localparam int NUM_REGS = NUM_EXT + 1;
  localparam int IDX_W = ADDR_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [7:0]  hold_q;
  logic [15:0] cnt_q;
  logic [15:0] sel_val;

  wire             is_hi  = bus_addr[0];
  wire [IDX_W-1:0] idx    = bus_addr[ADDR_W-1:1];
  wire             mapped = (idx <= LAST_IDX);
  wire             lo_rd  = bus_rd && !is_hi && mapped;
  wire             lo_wr  = bus_wr && !is_hi && mapped;
  wire             hi_wr  = bus_wr &&  is_hi && mapped;
  wire             cnt_wr = lo_wr && (idx == '0);

  always_comb begin
    sel_val = '0;
    if (idx == '0) sel_val = cnt_q;
    for (int k = 0; k < NUM_EXT; k++)
      if (idx == IDX_W'(k + 1)) sel_val = ext_value[k*16 +: 16];
  end

  assign bus_rdata = !(bus_rd && mapped) ? 8'h00 : (is_hi ? hold_q : sel_val[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)     hold_q <= '0;
    else if (hi_wr) hold_q <= bus_wdata;
    else if (lo_rd) hold_q <= sel_val[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= {hold_q, bus_wdata};
    else if (cnt_en)  cnt_q <= cnt_q + 16'd1;
  end

  assign cnt_value = cnt_q;
  assign ext_wdata = {hold_q, bus_wdata};

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_load
    assign ext_load[g] = lo_wr && (idx == IDX_W'(g + 1));
  end

  assert_lo_read_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> hold_q == $past(sel_val[15:8]));
  assert_hi_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_hi) |-> ext_load == '0);
  assert_hi_keeps_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_hi && !cnt_en) |=> $stable(cnt_value));
  assert_load_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_load));
  assert_wr_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_value == $past({hold_q, bus_wdata}));
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |-> bus_rdata == 8'h00);
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_wr) |=> cnt_value == $past(cnt_value) + 16'd1);
  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);
endmodule

// File: tb/sim_wide_reg_bridge.sv
module sim_wide_reg_bridge;
  localparam int ADDR_W = 4;
  localparam int NUM_EXT = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_rd = 0, bus_wr = 0, cnt_en = 0;
  logic [7:0] bus_rdata;
  logic [15:0] cnt_value, ext_wdata;
  logic [NUM_EXT-1:0] ext_load;
  logic [16*NUM_EXT-1:0] ext_value;
  logic [15:0] ext_reg [NUM_EXT];
  int load_cnt [NUM_EXT];
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wide_reg_bridge #(.ADDR_W(ADDR_W), .NUM_EXT(NUM_EXT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .cnt_value(cnt_value), .ext_load(ext_load), .ext_wdata(ext_wdata),
    .ext_value(ext_value));

  always_comb
    for (int k = 0; k < NUM_EXT; k++) ext_value[k*16 +: 16] = ext_reg[k];

  always_ff @(posedge clk)
    for (int k = 0; k < NUM_EXT; k++)
      if (ext_load[k]) begin
        ext_reg[k] <= ext_wdata;
        load_cnt[k] <= load_cnt[k] + 1;
      end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #1;
    check(cnt_value == 16'h0, "R1", cnt_value, 0);
    check(ext_load == '0, "R1", ext_load, 0);
    check(bus_rdata == 8'h00, "R9", bus_rdata, 0);
    rd(1, d);
    check(d == 8'h00, "R1", d, 0);
  endtask

  task automatic t_snapshot();
    logic [7:0] lo, hi;
    wr(1, 8'h12); wr(0, 8'hFF);
    check(cnt_value == 16'h12FF, "R4", cnt_value, 16'h12FF);
    cnt_en = 1;
    rd(0, lo);
    rd(1, hi);
    cnt_en = 0;
    #1;
    check(lo == 8'hFF, "R2", lo, 8'hFF);
    check(hi == 8'h12, "R2", hi, 8'h12);
    check(cnt_value == 16'h1301, "R8", cnt_value, 16'h1301);
  endtask

  task automatic t_write_priority();
    cnt_en = 1;
    wr(1, 8'hAB);
    wr(0, 8'hCD);
    cnt_en = 0;
    #1 check(cnt_value == 16'hABCD, "R5", cnt_value, 16'hABCD);
  endtask

  task automatic t_wrap();
    wr(1, 8'hFF); wr(0, 8'hFE);
    cnt_en = 1;
    repeat (3) @(negedge clk);
    cnt_en = 0;
    #1 check(cnt_value == 16'h0001, "R8", cnt_value, 1);
  endtask

  task automatic t_ext_write();
    logic [7:0] lo, hi;
    wr(3, 8'h5A); wr(2, 8'hC3);
    #1;
    check(load_cnt[0] == 1, "R4", load_cnt[0], 1);
    check(load_cnt[1] == 0, "R4", load_cnt[1], 0);
    check(ext_reg[0] == 16'h5AC3, "R4", ext_reg[0], 16'h5AC3);
    rd(2, lo); rd(3, hi);
    check({hi, lo} == 16'h5AC3, "R2", {hi, lo}, 16'h5AC3);
  endtask

  task automatic t_high_only();
    logic [7:0] d;
    logic [15:0] c0 = cnt_value, r1 = ext_reg[1];
    wr(5, 8'h77);
    #1;
    check(cnt_value == c0, "R3", cnt_value, c0);
    check(ext_reg[1] == r1 && load_cnt[1] == 0, "R3", ext_reg[1], r1);
    rd(5, d);
    check(d == 8'h77, "R3", d, 8'h77);
    check(ext_reg[1] == r1, "R3", ext_reg[1], r1);
  endtask

  task automatic t_shared_hold();
    logic [7:0] d;
    wr(1, 8'h11);
    rd(2, d);
    wr(0, 8'h22);
    #1 check(cnt_value == 16'h5A22, "R6", cnt_value, 16'h5A22);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [15:0] c0;
    wr(1, 8'h3C);
    c0 = cnt_value;
    rd(9, d);
    check(d == 8'h00, "R7", d, 0);
    rd(14, d);
    check(d == 8'h00, "R7", d, 0);
    wr(9, 8'h99); wr(8, 8'h66);
    #1;
    check(cnt_value == c0, "R7", cnt_value, c0);
    check(load_cnt[0] == 1 && load_cnt[1] == 0, "R7", load_cnt[0] + load_cnt[1], 1);
    rd(1, d);
    check(d == 8'h3C, "R7", d, 8'h3C);
    #1 check(bus_rdata == 8'h00, "R9", bus_rdata, 0);
  endtask

  initial begin
    for (int k = 0; k < NUM_EXT; k++) begin
      ext_reg[k] = 16'h0;
      load_cnt[k] = 0;
    end
    ext_reg[1] = 16'hBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_snapshot();
    t_write_priority();
    t_wrap();
    t_ext_write();
    t_high_only();
    t_shared_hold();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule